// File: doc/BRIEF.md
# Brown-Out Reset Sequencer

This block turns a synchronised "supply below threshold" indication into a chip reset request. A configuration mode, captured during the power-on event, decides when the detector is armed. The detector can be never armed, armed by a software enable bit, armed except while the chip sleeps, or always armed. A low indication counts only when it persists for a minimum number of consecutive clock cycles. Once a brown-out has tripped, the reset request is held for as long as the supply stays low.

When the supply recovers, the reset can be stretched by a power-up delay of a parameterised number of cycles. This delay has its own enable, separate from the detector mode. A new dip while the delay is running puts the block back into brown-out, and the delay starts again from zero. Two status flags tell software what caused the last reset. The brown-out flag is cleared by every brown-out and by every power-on event. The power-on flag is cleared only by a power-on event. Software sets either flag with a write strobe. A brown-out therefore shows as brown-out flag 0 with power-on flag 1.

The power-on event is the block's synchronous active-low reset `rst_n`. While `rst_n` is low, the mode and the delay enable are sampled and the reset request is driven high.

Top module: `brownout_seq`

## Requirements
- R1: The detector mode is captured from `cfg_mode_i` while `rst_n` is low. Mode 2'b00 never produces a brown-out. Mode 2'b11 is always armed. Mode 2'b10 is armed only while `sleep_i` is 0.
- R2: In mode 2'b01 the detector is armed exactly when the software enable is 1. The software enable is written through `swen_wr_i`/`swen_wdata_i` and reset to 0. In every other mode, writes are ignored and `swen_rd_o` reads 0.
- R3: While the detector is armed, `vdd_low_i` high for MIN_PULSE consecutive cycles raises `reset_req_o` exactly MIN_PULSE clock edges after it is first sampled. A run shorter than MIN_PULSE leaves `reset_req_o` and the flags unchanged.
- R4: After a brown-out trip, `reset_req_o` stays 1 for as long as `vdd_low_i` stays 1.
- R5: Recovery is timed from the first edge that samples `vdd_low_i` at 0. With the delay enable captured as 0, `reset_req_o` falls at that edge. With it captured as 1, `reset_req_o` falls PWRT_CYC+1 edges after the low-to-high change of the supply.
- R6: `vdd_low_i` high for a single cycle while the power-up delay runs (detector armed) returns the block to brown-out. `reset_req_o` stays 1, and the full delay is counted again from the next recovery.
- R7: `reset_req_o` is 1 while `rst_n` is 0. After release it falls PWRT_CYC edges later if `cfg_pwrt_en_i` was 1 during reset, whatever the detector mode. Later changes to the configuration inputs have no effect.
- R8: `bo_flag_o` is cleared by every brown-out trip, including a trip during the delay, and by `rst_n`. `po_flag_o` is cleared only by `rst_n`.
- R9: A cycle with `flag_set_i` high sets `bo_flag_o` where `flag_bo_i` is 1 and sets `po_flag_o` where `flag_po_i` is 1. A 0 data bit leaves that flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on event, synchronous, active low |
| cfg_mode_i | input | 2 | Detector mode, sampled during reset |
| cfg_pwrt_en_i | input | 1 | Power-up delay enable, sampled during reset |
| sleep_i | input | 1 | Chip is in sleep |
| vdd_low_i | input | 1 | Synchronised comparator output, 1 = supply below threshold |
| swen_wr_i | input | 1 | Software enable write strobe |
| swen_wdata_i | input | 1 | Software enable write value |
| flag_set_i | input | 1 | Status flag set strobe |
| flag_bo_i | input | 1 | Set brown-out flag with strobe |
| flag_po_i | input | 1 | Set power-on flag with strobe |
| reset_req_o | output | 1 | Chip reset request |
| swen_rd_o | output | 1 | Software enable readback |
| bo_flag_o | output | 1 | Brown-out status flag |
| po_flag_o | output | 1 | Power-on status flag |

## Verification
Each result has a fixed latency, counted in clock edges:

| Result | Due |
|---|---|
| Brown-out trip | MIN_PULSE edges after the supply drop is first sampled |
| Recovery without the delay | 1 edge after the supply rises |
| Recovery with the delay | PWRT_CYC+1 edges after the supply rises |
| Release after power-on | PWRT_CYC edges after `rst_n` rises |
| Flag writes and software enable writes | 1 edge |

The bench drives inputs just after a falling edge. It samples on later falling edges and counts those edges until `reset_req_o` changes, so every latency is checked as an exact number rather than a bound. For the negative cases it watches `reset_req_o` over a window longer than MIN_PULSE: the filter, the disabled modes and configuration changes made after reset.

// File: rtl/bor_pkg.sv
// Shared types for the brown-out reset sequencer.
// Assumes: mode encodings are fixed by the configuration field layout.
package bor_pkg;
    typedef enum logic [1:0] {
        BOR_OFF     = 2'b00,
        BOR_SW      = 2'b01,
        BOR_NOSLEEP = 2'b10,
        BOR_ON      = 2'b11
    } bor_mode_e;

    typedef enum logic [1:0] {
        SEQ_RUN   = 2'b00,
        SEQ_BROWN = 2'b01,
        SEQ_DELAY = 2'b10
    } seq_state_e;
endpackage

// File: rtl/bor_cfg.sv
// Configuration capture and detector arming.
// Captures the mode and delay enable while reset is low, holds the software
// enable bit (writable only in software mode) and decides when the detector
// is armed. Assumes all inputs are synchronous to clk.
module bor_cfg
    import bor_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic [1:0] mode_i,
    input  logic      pwrt_en_i,
    input  logic      sleep_i,
    input  logic      swen_wr_i,
    input  logic      swen_wdata_i,
    output bor_mode_e mode_o,
    output logic      pwrt_q_o,
    output logic      armed_o,
    output logic      swen_rd_o
);
    bor_mode_e mode_q;
    logic      pwrt_q;
    logic      swen_q;

    // Sample configuration only while the power-on event is active.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= bor_mode_e'(mode_i);
            pwrt_q <= pwrt_en_i;
        end
    end

    // Software enable register, writable only in software mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            swen_q <= 1'b0;
        end else if (swen_wr_i && (mode_q == BOR_SW)) begin
            swen_q <= swen_wdata_i;
        end
    end

    // Decide whether the detector is armed this cycle.
    always_comb begin
        case (mode_q)
            BOR_SW:      armed_o = swen_q;
            BOR_NOSLEEP: armed_o = !sleep_i;
            BOR_ON:      armed_o = 1'b1;
            default:     armed_o = 1'b0;
        endcase
    end

    assign swen_rd_o = (mode_q == BOR_SW) ? swen_q : 1'b0;
    assign mode_o    = mode_q;
    assign pwrt_q_o  = pwrt_q;

    assert_swen_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q != BOR_SW) |-> !swen_q);

    assert_mode_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(mode_q) && $stable(pwrt_q));
endmodule

// File: rtl/bor_filter.sv
// Glitch filter for the below-threshold indication.
// Counts consecutive armed low samples and flags a trip once MIN_PULSE
// of them have been seen. Assumes MIN_PULSE >= 2.
module bor_filter #(
    parameter int MIN_PULSE = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic low_i,
    input  logic armed_i,
    output logic trip_o
);
    localparam int CW = (MIN_PULSE > 2) ? $clog2(MIN_PULSE) : 1;
    localparam logic [CW-1:0] LAST = CW'(MIN_PULSE - 1);

    logic [CW-1:0] run_q;
    logic          low_armed;

    assign low_armed = low_i && armed_i;
    assign trip_o    = low_armed && (run_q == LAST);

    // Saturating run-length counter of armed low samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (!low_armed) begin
            run_q <= '0;
        end else if (run_q != LAST) begin
            run_q <= run_q + 1'b1;
        end
    end

    assert_trip_needs_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
        trip_o |-> $past(low_armed));
endmodule

// File: rtl/bor_sequencer.sv
// Reset sequencing state machine with power-up delay counter.
// RUN -> BROWN on a filtered trip; BROWN holds while low; recovery goes to
// DELAY (when enabled) which counts PWRT_CYC cycles; a dip in DELAY returns
// to BROWN. Assumes PWRT_CYC >= 1.
module bor_sequencer
    import bor_pkg::*;
#(
    parameter int PWRT_CYC = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwrt_en_i,
    input  logic       pwrt_q_i,
    input  logic       low_i,
    input  logic       armed_i,
    input  logic       trip_i,
    output seq_state_e state_o,
    output logic       bo_event_o
);
    localparam int DW = $clog2(PWRT_CYC + 1);
    localparam logic [DW-1:0] DLY_LAST = DW'(PWRT_CYC - 1);

    seq_state_e    state_q, state_d;
    logic [DW-1:0] dly_q, dly_d;

    // Next-state and delay counter logic.
    always_comb begin
        state_d    = state_q;
        dly_d      = dly_q;
        bo_event_o = 1'b0;
        case (state_q)
            SEQ_RUN: begin
                if (trip_i) begin
                    state_d    = SEQ_BROWN;
                    bo_event_o = 1'b1;
                end
            end
            SEQ_BROWN: begin
                if (!low_i) begin
                    state_d = pwrt_q_i ? SEQ_DELAY : SEQ_RUN;
                    dly_d   = '0;
                end
            end
            SEQ_DELAY: begin
                if (low_i && armed_i) begin
                    state_d    = SEQ_BROWN;
                    bo_event_o = 1'b1;
                end else if (dly_q == DLY_LAST) begin
                    state_d = SEQ_RUN;
                end else begin
                    dly_d = dly_q + 1'b1;
                end
            end
            default: state_d = SEQ_RUN;
        endcase
    end

    // State register; power-on starts the delay when it is enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= pwrt_en_i ? SEQ_DELAY : SEQ_RUN;
            dly_q   <= '0;
        end else begin
            state_q <= state_d;
            dly_q   <= dly_d;
        end
    end

    assign state_o = state_q;

    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dly_q < DW'(PWRT_CYC));

    assert_hold_while_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_BROWN) && low_i |=> (state_q == SEQ_BROWN));

    assert_delay_fresh_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == SEQ_BROWN) && (state_q == SEQ_DELAY) |-> (dly_q == '0));
endmodule

// File: rtl/bor_flags.sv
// Brown-out and power-on status flags.
// Flags are cleared by reset; the brown-out flag also by a brown-out event,
// which wins over a simultaneous software set.
module bor_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic bo_event_i,
    input  logic set_i,
    input  logic set_bo_i,
    input  logic set_po_i,
    output logic bo_o,
    output logic po_o
);
    // Brown-out flag: event clears, software sets.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bo_o <= 1'b0;
        end else if (bo_event_i) begin
            bo_o <= 1'b0;
        end else if (set_i && set_bo_i) begin
            bo_o <= 1'b1;
        end
    end

    // Power-on flag: only reset clears, software sets.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            po_o <= 1'b0;
        end else if (set_i && set_po_i) begin
            po_o <= 1'b1;
        end
    end

    assert_bo_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bo_event_i |=> !bo_o);

    assert_po_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(set_i && set_po_i) |=> (po_o == $past(po_o)));

    assert_po_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        set_i && set_po_i |=> po_o);
endmodule

// File: rtl/brownout_seq.sv
// Brown-out reset sequencer top level.
// Wires configuration, filter, sequencer and flags; reset_req_o is high
// during the power-on event and whenever the sequencer is not running.
// Assumes vdd_low_i is already synchronised to clk.
module brownout_seq
    import bor_pkg::*;
#(
    parameter int MIN_PULSE = 4,
    parameter int PWRT_CYC  = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] cfg_mode_i,
    input  logic       cfg_pwrt_en_i,
    input  logic       sleep_i,
    input  logic       vdd_low_i,
    input  logic       swen_wr_i,
    input  logic       swen_wdata_i,
    input  logic       flag_set_i,
    input  logic       flag_bo_i,
    input  logic       flag_po_i,
    output logic       reset_req_o,
    output logic       swen_rd_o,
    output logic       bo_flag_o,
    output logic       po_flag_o
);
    bor_mode_e  mode;
    seq_state_e state;
    logic       pwrt_q;
    logic       armed;
    logic       trip;
    logic       bo_event;

    bor_cfg u_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_i       (cfg_mode_i),
        .pwrt_en_i    (cfg_pwrt_en_i),
        .sleep_i      (sleep_i),
        .swen_wr_i    (swen_wr_i),
        .swen_wdata_i (swen_wdata_i),
        .mode_o       (mode),
        .pwrt_q_o     (pwrt_q),
        .armed_o      (armed),
        .swen_rd_o    (swen_rd_o)
    );

    bor_filter #(.MIN_PULSE(MIN_PULSE)) u_filter (
        .clk     (clk),
        .rst_n   (rst_n),
        .low_i   (vdd_low_i),
        .armed_i (armed),
        .trip_o  (trip)
    );

    bor_sequencer #(.PWRT_CYC(PWRT_CYC)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .pwrt_en_i  (cfg_pwrt_en_i),
        .pwrt_q_i   (pwrt_q),
        .low_i      (vdd_low_i),
        .armed_i    (armed),
        .trip_i     (trip),
        .state_o    (state),
        .bo_event_o (bo_event)
    );

    bor_flags u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .bo_event_i (bo_event),
        .set_i      (flag_set_i),
        .set_bo_i   (flag_bo_i),
        .set_po_i   (flag_po_i),
        .bo_o       (bo_flag_o),
        .po_o       (po_flag_o)
    );

    assign reset_req_o = !rst_n || (state != SEQ_RUN);

    assert_off_mode_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == BOR_OFF) && (state != SEQ_BROWN) |=> (state != SEQ_BROWN));

    assert_sleep_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == BOR_NOSLEEP) && sleep_i && (state == SEQ_RUN) |=> (state == SEQ_RUN));
endmodule

// File: tb/brownout_seq_tb_top.sv
module brownout_seq_tb_top;
    localparam int MIN_PULSE = 4;
    localparam int PWRT_CYC  = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] cfg_mode_i = 2'b00;
    logic       cfg_pwrt_en_i = 1'b0;
    logic       sleep_i = 1'b0;
    logic       vdd_low_i = 1'b0;
    logic       swen_wr_i = 1'b0;
    logic       swen_wdata_i = 1'b0;
    logic       flag_set_i = 1'b0;
    logic       flag_bo_i = 1'b0;
    logic       flag_po_i = 1'b0;
    logic       reset_req_o, swen_rd_o, bo_flag_o, po_flag_o;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    always #2 clk = ~clk;

    brownout_seq #(.MIN_PULSE(MIN_PULSE), .PWRT_CYC(PWRT_CYC)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_mode_i(cfg_mode_i), .cfg_pwrt_en_i(cfg_pwrt_en_i),
        .sleep_i(sleep_i), .vdd_low_i(vdd_low_i), .swen_wr_i(swen_wr_i),
        .swen_wdata_i(swen_wdata_i), .flag_set_i(flag_set_i), .flag_bo_i(flag_bo_i),
        .flag_po_i(flag_po_i), .reset_req_o(reset_req_o), .swen_rd_o(swen_rd_o),
        .bo_flag_o(bo_flag_o), .po_flag_o(po_flag_o)
    );

    // Vector: {mode[5:4], write swen=1 [3], sleep [2], expect reset [1], expect swen_rd [0]}
    localparam logic [5:0] MODE_VEC [8] = '{
        {2'b00, 1'b1, 1'b0, 1'b0, 1'b0},
        {2'b01, 1'b0, 1'b0, 1'b0, 1'b0},
        {2'b01, 1'b1, 1'b0, 1'b1, 1'b1},
        {2'b01, 1'b1, 1'b1, 1'b1, 1'b1},
        {2'b10, 1'b0, 1'b0, 1'b1, 1'b0},
        {2'b10, 1'b1, 1'b1, 1'b0, 1'b0},
        {2'b11, 1'b1, 1'b1, 1'b1, 1'b0},
        {2'b11, 1'b0, 1'b0, 1'b1, 1'b0}
    };

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Power-on event; entered and left just after a falling edge.
    task automatic do_por(input logic [1:0] m, input logic p);
        cfg_mode_i    = m;
        cfg_pwrt_en_i = p;
        vdd_low_i     = 1'b0;
        sleep_i       = 1'b0;
        rst_n         = 1'b0;
        repeat (3) @(negedge clk);
        check("R7 reset_req during power-on", int'(reset_req_o), 1);
        rst_n = 1'b1;
    endtask

    // Count falling edges until reset_req_o reaches val.
    task automatic wait_rst(input logic val, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (reset_req_o !== val && n < 500);
    endtask

    task automatic set_flags(input logic b, input logic p);
        flag_set_i = 1'b1;
        flag_bo_i  = b;
        flag_po_i  = p;
        @(negedge clk);
        flag_set_i = 1'b0;
        flag_bo_i  = 1'b0;
        flag_po_i  = 1'b0;
    endtask

    task automatic write_swen(input logic v);
        swen_wr_i    = 1'b1;
        swen_wdata_i = v;
        @(negedge clk);
        swen_wr_i    = 1'b0;
        swen_wdata_i = 1'b0;
    endtask

    initial begin
        int n;
        int bad;
        @(negedge clk);

        // Reset state and power-up delay after power-on
        do_por(2'b11, 1'b1);
        check("R8 bo_flag after power-on", int'(bo_flag_o), 0);
        check("R8 po_flag after power-on", int'(po_flag_o), 0);
        check("R2 swen_rd after power-on", int'(swen_rd_o), 0);
        wait_rst(1'b0, n);
        check("R7 power-up delay after release", n, PWRT_CYC);

        // Software flag setting
        set_flags(1'b0, 1'b1);
        check("R9 po set", int'(po_flag_o), 1);
        check("R9 bo untouched by 0 bit", int'(bo_flag_o), 0);
        set_flags(1'b1, 1'b0);
        check("R9 bo set", int'(bo_flag_o), 1);
        check("R9 po untouched by 0 bit", int'(po_flag_o), 1);

        // Filter, hold and recovery without delay
        do_por(2'b11, 1'b0);
        @(negedge clk);
        set_flags(1'b1, 1'b1);
        vdd_low_i = 1'b1;
        repeat (MIN_PULSE - 1) @(negedge clk);
        vdd_low_i = 1'b0;
        bad = 0;
        repeat (MIN_PULSE + 2) begin
            @(negedge clk);
            if (reset_req_o !== 1'b0) bad++;
        end
        check("R3 short dip ignored", bad, 0);
        check("R3 short dip keeps bo_flag", int'(bo_flag_o), 1);
        vdd_low_i = 1'b1;
        wait_rst(1'b1, n);
        check("R3 trip latency", n, MIN_PULSE);
        check("R8 bo cleared by brown-out", int'(bo_flag_o), 0);
        check("R8 po kept by brown-out", int'(po_flag_o), 1);
        bad = 0;
        repeat (30) begin
            @(negedge clk);
            if (reset_req_o !== 1'b1) bad++;
        end
        check("R4 reset held while low", bad, 0);
        vdd_low_i = 1'b0;
        wait_rst(1'b0, n);
        check("R5 recovery without delay", n, 1);

        // Recovery with delay
        do_por(2'b11, 1'b1);
        wait_rst(1'b0, n);
        vdd_low_i = 1'b1;
        repeat (MIN_PULSE + 3) @(negedge clk);
        vdd_low_i = 1'b0;
        wait_rst(1'b0, n);
        check("R5 recovery with delay", n, PWRT_CYC + 1);

        // Dip during delay restarts it
        set_flags(1'b1, 1'b0);
        vdd_low_i = 1'b1;
        repeat (MIN_PULSE + 3) @(negedge clk);
        vdd_low_i = 1'b0;
        repeat (20) @(negedge clk);
        set_flags(1'b1, 1'b0);
        check("R6 reset high mid-delay", int'(reset_req_o), 1);
        vdd_low_i = 1'b1;
        @(negedge clk);
        vdd_low_i = 1'b0;
        wait_rst(1'b0, n);
        check("R6 delay restarted by dip", n, PWRT_CYC + 1);
        check("R8 bo cleared by dip in delay", int'(bo_flag_o), 0);

        // Delay independent of detector mode; configuration sampled only in reset
        do_por(2'b00, 1'b1);
        wait_rst(1'b0, n);
        check("R7 delay with detector off", n, PWRT_CYC);
        cfg_mode_i    = 2'b11;
        cfg_pwrt_en_i = 1'b0;
        vdd_low_i     = 1'b1;
        bad = 0;
        repeat (MIN_PULSE + 6) begin
            @(negedge clk);
            if (reset_req_o !== 1'b0) bad++;
        end
        check("R7/R1 mode change after reset ignored", bad, 0);
        vdd_low_i = 1'b0;

        // Power-on clears the power-on flag
        set_flags(1'b1, 1'b1);
        check("R9 both set", int'(po_flag_o) + int'(bo_flag_o), 2);
        do_por(2'b11, 1'b0);
        check("R8 po cleared by power-on", int'(po_flag_o), 0);
        check("R8 bo cleared by power-on", int'(bo_flag_o), 0);

        // Mode table
        foreach (MODE_VEC[i]) begin
            do_por(MODE_VEC[i][5:4], 1'b0);
            @(negedge clk);
            if (MODE_VEC[i][3]) write_swen(1'b1);
            sleep_i = MODE_VEC[i][2];
            check($sformatf("R2 swen_rd vector %0d", i), int'(swen_rd_o), int'(MODE_VEC[i][0]));
            vdd_low_i = 1'b1;
            repeat (MIN_PULSE + 4) @(negedge clk);
            check($sformatf("R1/R2 reset vector %0d", i), int'(reset_req_o), int'(MODE_VEC[i][1]));
            vdd_low_i = 1'b0;
            sleep_i   = 1'b0;
            repeat (2) @(negedge clk);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog (all requirements): actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule